// File: doc/BRIEF.md
# Latched External Interrupt Controller

This block sits between an external interrupt pin and a small CPU sequencer. The pin is synchronised and must hold its active level for a set number of clock cycles. When it does, a request latch is set. The latch records the request whatever the masks say. The masks act only on the latch output, so software can see a request that arrived while it was masked and can cancel it before it lowers the masks. This stops a stale request from entering the service routine once the masks are cleared.

A one-byte status and control register is mapped into the CPU's address space. It holds a local mask bit, a read-only view of the latch and a write-only acknowledge bit. The sequencer supplies a global mask level, a strobe at the end of each instruction, a strobe when it takes the hardware interrupt, and a flag that says the next opcode is a software interrupt. At each instruction boundary the block decides which service, if any, starts, and it drives the addresses of the high and low vector bytes for that service.

Top module: `irq_latch_ctrl`

## Requirements
- R1: The pin is passed through two synchronising flops. A request is qualified after the synchronised pin has been at its active level (low by default) for QUAL_CYC consecutive cycles. A shorter excursion sets nothing, and one long excursion gives exactly one qualification.
- R2: A qualified request sets the latch even when the local mask, the global mask or both are set.
- R3: `irq_pending` is high exactly when the latch is set, `glb_mask` is low and the local mask bit is clear.
- R4: A read of the register (`reg_sel` high, `reg_wr` low) returns the latch state in bit 3 and the local mask in bit 1. All other bits, including the acknowledge bit 2, read as zero.
- R5: A `hw_taken` strobe clears the latch on the next clock edge.
- R6: A register write with bit 2 set clears the latch. The acknowledge is one-shot: it leaves nothing behind, and a later request latches normally. The same write loads bit 1 into the local mask.
- R7: If a qualification coincides with an acknowledge write or with `hw_taken`, the latch stays set.
- R8: A service starts only while `insn_end` is high. An enabled hardware request wins over a software interrupt. A software interrupt is serviced regardless of `glb_mask` and of the local mask.
- R9: For a software interrupt the vector byte addresses are 0x0FFC (high) and 0x0FFD (low). For a hardware interrupt they are HW_VEC and HW_VEC+1, with a default of 0x0FFA and 0x0FFB. With no service, both addresses are zero.
- R10: After reset the latch is clear, the local mask is set (a read returns 0x02), and `irq_pending` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pin | input | 1 | External interrupt pin, asynchronous |
| glb_mask | input | 1 | Global interrupt mask from the CPU condition codes |
| insn_end | input | 1 | Strobe: the current instruction completes this cycle |
| hw_taken | input | 1 | Strobe: the CPU has taken the hardware interrupt |
| swi_next | input | 1 | The next opcode is a software interrupt |
| reg_sel | input | 1 | Register select |
| reg_wr | input | 1 | Write enable for the register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, zero when not selected |
| irq_pending | output | 1 | Enabled hardware request |
| svc_hw | output | 1 | Hardware service starts at this boundary |
| svc_sw | output | 1 | Software service starts at this boundary |
| vec_hi_addr | output | 16 | Address of the vector high byte |
| vec_lo_addr | output | 16 | Address of the vector low byte |

## Verification
The bench aims qualification at the same cycle as an acknowledge write and at the same cycle as a `hw_taken` strobe. A design that let the clear win would lose that request. It sets the latch while each mask is raised in turn: a design that gated the pin before the latch would leave the bit at 3 clear, and one that gated after the latch but ignored a mask would raise `irq_pending` anyway. It sends a pulse one cycle shorter than the qualification window, which a miscounting qualifier would accept. It offers a software interrupt beside an enabled hardware request and also under the global mask. A wrong arbiter would take the software path first, block it under the mask, or drive the wrong vector bytes.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int REG_W     = 8;
  localparam int BIT_MASK  = 1;
  localparam int BIT_ACK   = 2;
  localparam int BIT_REQ   = 3;

  // Address of the low vector byte follows the high byte.
  function automatic logic [15:0] vec_low(input logic [15:0] hi);
    return hi + 16'd1;
  endfunction

  // Register read image from latch and mask state.
  function automatic logic [REG_W-1:0] reg_image(input logic req, input logic msk);
    logic [REG_W-1:0] v;
    v = '0;
    v[BIT_REQ]  = req;
    v[BIT_MASK] = msk;
    return v;
  endfunction
endpackage

// File: rtl/irq_pin_qual.sv
module irq_pin_qual #(
  parameter int   QUAL_CYC   = 4,
  parameter logic ACTIVE_LVL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic qual_ev
);
  localparam int CNT_W = $clog2(QUAL_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(QUAL_CYC);
  localparam logic [CNT_W-1:0] CNT_HIT = CNT_W'(QUAL_CYC - 1);

  logic             sync_a, sync_b;
  logic             active;
  logic [CNT_W-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= ~ACTIVE_LVL;
      sync_b <= ~ACTIVE_LVL;
    end else begin
      sync_a <= pin;
      sync_b <= sync_a;
    end
  end

  assign active = (sync_b == ACTIVE_LVL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                run_cnt <= '0;
    else if (!active)          run_cnt <= '0;
    else if (run_cnt != CNT_TOP) run_cnt <= run_cnt + 1'b1;
  end

  assign qual_ev = active && (run_cnt == CNT_HIT);

  // R1: one qualification per excursion
  p_single_qual_r1: assert property (@(posedge clk) disable iff (!rst_n)
    qual_ev |=> !qual_ev);
  // R1: qualification only while the synchronised pin is active
  p_qual_active_r1: assert property (@(posedge clk) disable iff (!rst_n)
    qual_ev |-> (sync_b == ACTIVE_LVL));
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic ack_ev,
  input  logic take_ev,
  output logic req_q
);
  logic clr_ev;
  assign clr_ev = ack_ev | take_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      req_q <= 1'b0;
    else if (set_ev) req_q <= 1'b1;
    else if (clr_ev) req_q <= 1'b0;
  end

  // R2: a qualified request always lands in the latch
  p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> req_q);
  // R6: acknowledge without a new request empties the latch
  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_ev && !set_ev) |=> !req_q);
  // R5: taking the interrupt empties the latch
  p_take_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take_ev && !set_ev) |=> !req_q);
  // R7: a coinciding new request survives the clear
  p_new_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_ev && clr_ev) |=> req_q);
endmodule

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg
  import irq_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             req_q,
  output logic [REG_W-1:0] rdata,
  output logic             loc_mask,
  output logic             ack_ev
);
  logic wr_ev;
  assign wr_ev  = sel && wr;
  assign ack_ev = wr_ev && wdata[BIT_ACK];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     loc_mask <= 1'b1;
    else if (wr_ev) loc_mask <= wdata[BIT_MASK];
  end

  assign rdata = (sel && !wr) ? reg_image(req_q, loc_mask) : '0;

  // R4: the acknowledge bit never reads back
  p_ack_reads_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata[BIT_ACK]);
  // R6: the mask follows the written value
  p_mask_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ev |=> (loc_mask == $past(wdata[BIT_MASK])));
endmodule

// File: rtl/irq_svc_arb.sv
module irq_svc_arb #(
  parameter logic [15:0] HW_VEC = 16'h0FFA,
  parameter logic [15:0] SW_VEC = 16'h0FFC
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hw_en,
  input  logic        boundary,
  input  logic        swi_next,
  output logic        svc_hw,
  output logic        svc_sw,
  output logic [15:0] vec_hi,
  output logic [15:0] vec_lo
);
  import irq_ctrl_pkg::*;

  assign svc_hw = boundary && hw_en;
  assign svc_sw = boundary && swi_next && !hw_en;

  always_comb begin
    vec_hi = '0;
    vec_lo = '0;
    if (svc_hw) begin
      vec_hi = HW_VEC;
      vec_lo = vec_low(HW_VEC);
    end else if (svc_sw) begin
      vec_hi = SW_VEC;
      vec_lo = vec_low(SW_VEC);
    end
  end

  // R8: at most one service per boundary, and only at a boundary
  p_one_svc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({svc_hw, svc_sw}) && ((svc_hw || svc_sw) -> boundary));
  // R9: the software vector pair is fixed
  p_sw_vec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    svc_sw |-> (vec_hi == SW_VEC && vec_lo == SW_VEC + 16'd1));
endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int          QUAL_CYC   = 4,
  parameter logic        ACTIVE_LVL = 1'b0,
  parameter logic [15:0] HW_VEC     = 16'h0FFA,
  parameter logic [15:0] SW_VEC     = 16'h0FFC
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        irq_pin,
  input  logic        glb_mask,
  input  logic        insn_end,
  input  logic        hw_taken,
  input  logic        swi_next,
  input  logic        reg_sel,
  input  logic        reg_wr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic        irq_pending,
  output logic        svc_hw,
  output logic        svc_sw,
  output logic [15:0] vec_hi_addr,
  output logic [15:0] vec_lo_addr
);
  logic qual_ev;
  logic ack_ev;
  logic req_q;
  logic loc_mask;

  irq_pin_qual #(.QUAL_CYC(QUAL_CYC), .ACTIVE_LVL(ACTIVE_LVL)) u_qual (
    .clk(clk), .rst_n(rst_n), .pin(irq_pin), .qual_ev(qual_ev));

  irq_req_latch u_latch (
    .clk(clk), .rst_n(rst_n), .set_ev(qual_ev), .ack_ev(ack_ev),
    .take_ev(hw_taken), .req_q(req_q));

  irq_ctl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .sel(reg_sel), .wr(reg_wr), .wdata(reg_wdata),
    .req_q(req_q), .rdata(reg_rdata), .loc_mask(loc_mask), .ack_ev(ack_ev));

  assign irq_pending = req_q && !glb_mask && !loc_mask;

  irq_svc_arb #(.HW_VEC(HW_VEC), .SW_VEC(SW_VEC)) u_arb (
    .clk(clk), .rst_n(rst_n), .hw_en(irq_pending), .boundary(insn_end),
    .swi_next(swi_next), .svc_hw(svc_hw), .svc_sw(svc_sw),
    .vec_hi(vec_hi_addr), .vec_lo(vec_lo_addr));

  // R8: an enabled hardware request pre-empts a software interrupt
  p_hw_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_end && irq_pending) |-> (svc_hw && !svc_sw));
  // R3: pending never shows while either mask is up
  p_masked_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_mask || reg_rdata[BIT_MASK]) |-> !irq_pending);
endmodule

// File: tb/irq_latch_ctrl_tb.sv
module irq_latch_ctrl_tb;
  localparam int QUAL = 4;
  localparam int NV = 5;
  // {hit pin, local mask, global mask, expected pending}
  localparam logic [3:0] VEC [NV] = '{4'b1001, 4'b1100, 4'b1010, 4'b0000, 4'b1110};

  logic clk = 0, rst_n = 0;
  logic irq_pin = 1, glb_mask = 0, insn_end = 0, hw_taken = 0, swi_next = 0;
  logic reg_sel = 0, reg_wr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic irq_pending, svc_hw, svc_sw;
  logic [15:0] vec_hi_addr, vec_lo_addr;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_latch_ctrl #(.QUAL_CYC(QUAL)) u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    reg_sel = 1; reg_wr = 1; reg_wdata = d;
    @(negedge clk);
    reg_sel = 0; reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic rd(output logic [7:0] d);
    reg_sel = 1; reg_wr = 0;
    #1 d = reg_rdata;
    reg_sel = 0;
  endtask

  task automatic pulse(input int n);
    irq_pin = 0;
    repeat (n) @(negedge clk);
    irq_pin = 1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (2) @(negedge clk);
    rd(d);
    chk("R10 reset read", d, 8'h02);
    chk("R10 reset pending", irq_pending, 0);
    rst_n = 1;
    @(negedge clk);

    foreach (VEC[i]) begin
      glb_mask = 0;
      wr({5'b0, 1'b1, VEC[i][2], 1'b0});
      if (VEC[i][3]) pulse(QUAL + 1);
      glb_mask = VEC[i][1];
      #1;
      chk("R3 pending", irq_pending, VEC[i][0]);
      rd(d);
      chk("R2/R4 req bit", d, {4'b0, VEC[i][3], 1'b0, VEC[i][2], 1'b0});
      @(negedge clk);
    end
    glb_mask = 0;

    // R1 short pulse
    wr(8'h04);
    pulse(QUAL - 1);
    rd(d);
    chk("R1 short pulse", d[3], 0);
    pulse(QUAL + 6);
    rd(d);
    chk("R1 long pulse", d[3], 1);
    // R6 ack one-shot
    wr(8'h04);
    rd(d);
    chk("R6 ack clears, mask loaded", d, 8'h00);
    pulse(QUAL);
    rd(d);
    chk("R6 later request latches", d, 8'h08);
    // R5 take clears
    hw_taken = 1; @(negedge clk); hw_taken = 0;
    chk("R5 take clears", irq_pending, 0);
    // R7 coincidence with ack
    irq_pin = 0;
    repeat (QUAL + 1) @(negedge clk);
    wr(8'h04);
    irq_pin = 1;
    rd(d);
    chk("R7 new wins over ack", d[3], 1);
    // R7 coincidence with take
    wr(8'h04);
    repeat (3) @(negedge clk);
    irq_pin = 0;
    repeat (QUAL + 1) @(negedge clk);
    hw_taken = 1; @(negedge clk); hw_taken = 0;
    irq_pin = 1;
    rd(d);
    chk("R7 new wins over take", d[3], 1);
    // R8/R9 arbitration
    swi_next = 1;
    #1;
    chk("R8 no boundary", {svc_hw, svc_sw}, 2'b00);
    chk("R9 idle vector", vec_hi_addr, 16'h0000);
    insn_end = 1;
    #1;
    chk("R8 hw first", {svc_hw, svc_sw}, 2'b10);
    chk("R9 hw hi", vec_hi_addr, 16'h0FFA);
    chk("R9 hw lo", vec_lo_addr, 16'h0FFB);
    glb_mask = 1;
    #1;
    chk("R8 swi under mask", {svc_hw, svc_sw}, 2'b01);
    chk("R9 swi hi", vec_hi_addr, 16'h0FFC);
    chk("R9 swi lo", vec_lo_addr, 16'h0FFD);
    @(negedge clk);
    insn_end = 0; swi_next = 0; glb_mask = 0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule